// File: doc/BRIEF.md
# Eight-Symbol Pattern Detector

This block watches a stream of 3-bit symbols, one symbol taken on every rising clock edge, and pulses a single-bit flag when a fixed run of eight symbols has just arrived on back-to-back cycles. The target run is 001, 101, 110, 000, 110, 110, 011, 101, with 001 first. Because the run contains repeated values, a symbol that breaks a partial match must not always send the machine back to the start. The next state is the longest part of the pattern's beginning that still matches the latest symbols.

The machine keeps its progress as a match length from 0 to 7. A transition table covers every (length, symbol) pair. It is worked out at elaboration from the pattern parameter, so another pattern or width only needs new parameter values. After a complete match the machine carries on from the longest proper prefix of the pattern that is also its tail, so occurrences that overlap are all reported. The flag is registered. It is high for exactly the one cycle that follows the edge where the eighth symbol is taken. An asynchronous active-low reset clears both the progress and the flag.

Top module: `symdet_top`

## Requirements
- R1: While rst_n is low, found_o is 0 at once, without waiting for a clock edge. Reset also clears all match progress, so symbols taken before reset never count toward a later match.
- R2: When the last eight symbols taken on consecutive rising edges equal the pattern, found_o is 1 during the clock cycle that follows the edge that took the eighth symbol.
- R3: found_o is 0 in every cycle not covered by R2, and a single match never keeps it high for more than one cycle.
- R4: After a mismatch the machine keeps the longest pattern prefix that ends the received stream. For example, 001 arriving in the middle of a partial match restarts progress at length one, so 001, 001, 101, 110, 000, 110, 110, 011, 101 is detected.
- R5: Occurrences that follow each other directly are each reported. Two patterns sent back to back give two one-cycle pulses, eight cycles apart.
- R6: Any other symbol inserted at any position of the run (value 111 in the tests) prevents detection of that run.
- R7: sym_i[2:0] carries the symbol as an unsigned binary value. The pattern is taken in the order 1, 5, 6, 0, 6, 6, 3, 5 (decimal values of the 3-bit symbols).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; a symbol is taken on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 3 | Incoming symbol |
| found_o | output | 1 | Registered one-cycle pulse on a completed match |

## Verification
The bench builds the block with its default parameters: 3-bit symbols and the eight-symbol pattern. With these values all eight symbol codes can occur, including 111, which is not in the pattern. Every break position from the first to the eighth symbol is covered, as are a restart on a repeated 001, back-to-back occurrences and a reset in the middle of a run. The expected flag comes from a bench-side history of the last eight symbols compared directly with the pattern, not from a state machine. Random streams are biased toward pattern prefixes, so that deep partial matches and their fallbacks happen often.

// File: rtl/symdet_pkg.sv
package symdet_pkg;
  localparam int SYM_W_DEF   = 3;
  localparam int PAT_LEN_DEF = 8;
  // symbol 0 sits in the low bits; arrival order is 1,5,6,0,6,6,3,5
  localparam logic [PAT_LEN_DEF*SYM_W_DEF-1:0] PATTERN_DEF =
    {3'd5, 3'd3, 3'd6, 3'd6, 3'd0, 3'd6, 3'd5, 3'd1};
endpackage

// File: rtl/symdet_trans_table.sv
module symdet_trans_table #(
  parameter int SYM_W   = 3,
  parameter int PAT_LEN = 8,
  parameter logic [PAT_LEN*SYM_W-1:0] PATTERN = symdet_pkg::PATTERN_DEF,
  localparam int ST_W  = $clog2(PAT_LEN),
  localparam int CNT_W = $clog2(PAT_LEN+1)
) (
  input  logic [ST_W-1:0]  state_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [ST_W-1:0]  next_o,
  output logic             hit_o
);
  localparam int NSYM  = 1 << SYM_W;
  localparam int IDX_W = ST_W + SYM_W;
  localparam int DEPTH = 1 << IDX_W;

  function automatic int pat_sym(input int i);
    return int'(PATTERN[i*SYM_W +: SYM_W]);
  endfunction

  // longest prefix of the pattern that ends the stream P[0..s-1], c
  function automatic int next_len(input int s, input int c);
    int seq [PAT_LEN+1];
    bit ok;
    for (int i = 0; i < PAT_LEN + 1; i++) seq[i] = 0;
    for (int i = 0; i < s; i++) seq[i] = pat_sym(i);
    seq[s] = c;
    for (int k = s + 1; k >= 1; k--) begin
      ok = 1'b1;
      for (int j = 0; j < k; j++)
        if (pat_sym(j) != seq[s + 1 - k + j]) ok = 1'b0;
      if (ok) return k;
    end
    return 0;
  endfunction

  // longest proper prefix that is also a suffix of the whole pattern
  function automatic int full_fallback();
    bit ok;
    for (int k = PAT_LEN - 1; k >= 1; k--) begin
      ok = 1'b1;
      for (int j = 0; j < k; j++)
        if (pat_sym(j) != pat_sym(PAT_LEN - k + j)) ok = 1'b0;
      if (ok) return k;
    end
    return 0;
  endfunction

  localparam int FB_FULL = full_fallback();

  logic [CNT_W-1:0] tbl [DEPTH];

  for (genvar s = 0; s < (1 << ST_W); s++) begin : g_state
    for (genvar c = 0; c < NSYM; c++) begin : g_sym
      if (s < PAT_LEN) begin : g_live
        localparam int NL = next_len(s, c);
        assign tbl[s*NSYM + c] = CNT_W'(NL);
      end else begin : g_dead
        assign tbl[s*NSYM + c] = '0;
      end
    end
  end

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] len;

  always_comb begin
    idx    = {state_i, sym_i};
    len    = tbl[idx];
    hit_o  = (len == CNT_W'(PAT_LEN));
    next_o = hit_o ? ST_W'(FB_FULL) : len[ST_W-1:0];
  end
endmodule

// File: rtl/symdet_core.sv
module symdet_core #(
  parameter int SYM_W   = 3,
  parameter int PAT_LEN = 8,
  parameter logic [PAT_LEN*SYM_W-1:0] PATTERN = symdet_pkg::PATTERN_DEF,
  localparam int ST_W = $clog2(PAT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_i,
  output logic             found_o
);
  logic [ST_W-1:0] state_q, state_d;
  logic            hit;
  logic            found_q;

  symdet_trans_table #(
    .SYM_W(SYM_W), .PAT_LEN(PAT_LEN), .PATTERN(PATTERN)
  ) u_table (
    .state_i(state_q),
    .sym_i  (sym_i),
    .next_o (state_d),
    .hit_o  (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      found_q <= 1'b0;
    end else begin
      state_q <= state_d;
      found_q <= hit;
    end
  end

  assign found_o = found_q;

  // R1: flag cleared as soon as reset is asserted
  always_comb begin
    if (!rst_n) a_r1_reset_clear: assert (!found_q);
  end

  // R2: a completed match shows up one cycle later
  a_r2_hit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> found_q);

  // R3: pulse lasts a single cycle
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |=> !found_q);

  // R4: progress grows by at most one symbol per cycle
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, state_q} <= {1'b0, $past(state_q)} + 1'b1));
endmodule

// File: rtl/symdet_top.sv
module symdet_top #(
  parameter int SYM_W   = symdet_pkg::SYM_W_DEF,
  parameter int PAT_LEN = symdet_pkg::PAT_LEN_DEF,
  parameter logic [PAT_LEN*SYM_W-1:0] PATTERN = symdet_pkg::PATTERN_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_i,
  output logic             found_o
);
  symdet_core #(
    .SYM_W(SYM_W), .PAT_LEN(PAT_LEN), .PATTERN(PATTERN)
  ) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .sym_i  (sym_i),
    .found_o(found_o)
  );
endmodule

// File: tb/symdet_top_tb_top.sv
`timescale 1ns/1ps
module symdet_top_tb_top;
  localparam logic [23:0] PAT = {3'd5, 3'd3, 3'd6, 3'd6, 3'd0, 3'd6, 3'd5, 3'd1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sym_i = 3'd0;
  logic       found_o;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;
  logic [23:0] hist = '0;
  int   cnt = 0;
  logic exp_found = 1'b0;

  symdet_top dut_i (.clk(clk), .rst_n(rst_n), .sym_i(sym_i), .found_o(found_o));

  always #4 clk = ~clk;

  function automatic logic [2:0] pat_at(input int i);
    return PAT[i*3 +: 3];
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (found_o !== exp_found) begin
      n_fails++;
      $display("FAIL %s: found_o=%0b expected %0b", tag, found_o, exp_found);
    end
  endtask

  // check the result of the previous edge, then present a new symbol
  task automatic send(input logic [2:0] s, input string tag);
    @(negedge clk);
    check(tag);
    sym_i = s;
    hist  = {s, hist[23:3]};
    cnt++;
    exp_found = (cnt >= 8) && (hist == PAT);
  endtask

  task automatic flush(input string tag);
    @(negedge clk);
    check(tag);
    exp_found = 1'b0;
  endtask

  task automatic send_pat(input string tag);
    for (int i = 0; i < 8; i++) send(pat_at(i), tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    check("R1");
    #2 rst_n = 1'b0;
    #1;
    exp_found = 1'b0;
    check("R1");
    hist = '0;
    cnt  = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    #3;
    check("R1");
    repeat (2) @(negedge clk);
    check("R1");
    rst_n = 1'b1;

    // R7 / R2: plain pattern, in stated order
    send_pat("R7");
    flush("R2");
    send(3'd0, "R3");
    flush("R3");

    // R5: back-to-back occurrences
    send_pat("R5");
    send_pat("R5");
    send_pat("R5");
    flush("R5");

    // R4: repeated 001 before the run restarts at length one
    send(3'd1, "R4");
    send_pat("R4");
    flush("R4");
    // R4: 001 mid-run, then the whole pattern
    for (int i = 0; i < 5; i++) send(pat_at(i), "R4");
    send_pat("R4");
    flush("R4");

    // R6: break at each position with symbol 111
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < p; i++) send(pat_at(i), "R6");
      send(3'd7, "R6");
      for (int i = p; i < 8; i++) send(pat_at(i), "R6");
      flush("R6");
    end

    // R1: reset mid-run, progress must be lost
    for (int i = 0; i < 4; i++) send(pat_at(i), "R1");
    do_reset();
    for (int i = 4; i < 8; i++) send(pat_at(i), "R1");
    flush("R1");

    // random traffic biased toward prefixes
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 2) send_pat("R2");
      else if (r < 6) begin
        int k;
        k = int'($urandom % 8);
        for (int i = 0; i < k; i++) send(pat_at(i), "R4");
        send(3'($urandom), "R4");
      end else send(3'($urandom), "R3");
    end
    flush("R3");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule